// File: doc/BRIEF.md
# Latched-Input Serial-Out Shift Register

This block turns a parallel byte into a serial bit stream. A storage latch first takes a snapshot of the parallel input bus. A shift register then takes that snapshot on command, or it is filled one bit at a time from a serial input. The shift register's last stage drives a single serial output. That output can be released to high impedance, so several of these blocks can share one serial return line, such as the data-out line of an SPI bus.

All storage runs on one system clock. The latch strobe and the shift strobe are plain inputs that are sampled on that clock, and each acts only on its rising transition. A mode input chooses what a shift strobe does: copy the latch into the shift register, or shift one place. The output stage is a data bit plus a drive flag. The tri-state assignment sits only at the top level. The drive flag is also brought out so that pad logic can use it.

Top module: `latched_shift_out`

## Requirements
- R1: After reset, both the latch and the shift register hold all zeros, so the serial data reads 0 when it is driven. A latch image captured before a reset is lost after that reset.
- R2: A rising transition of `latch_clk_i` (sampled 0 then 1 on consecutive system clocks) copies `par_i` into the latch. It leaves the shift register unchanged.
- R3: A rising transition of `shift_clk_i` with `shift_mode_i` = 0 copies the latch into the shift register. Bit i of the latch goes to stage i, so latch bit W-1 appears on `sdo_o` at once.
- R4: A rising transition of `shift_clk_i` with `shift_mode_i` = 1 moves every stage one place toward stage W-1 and loads `ser_i` into stage 0. The bits of the previously loaded byte therefore leave from the top down, followed by the serial bits in the order they entered.
- R5: When a latch capture and a copy to the shift register happen on the same system clock, the shift register receives the latch contents from before that capture.
- R6: With `oe_ni` = 1, `sdo_oe_o` is 0 and `sdo_o` is high impedance. With `oe_ni` = 0, `sdo_oe_o` is 1 and `sdo_o` carries stage W-1.
- R7: `oe_ni` has no effect on either register. Shifts that happen while the output is disabled still take place.
- R8: A strobe input that stays high acts only once. Holding `shift_clk_i` high shifts only one place. Holding `latch_clk_i` high does not follow later changes on `par_i`.
- R9: `shift_mode_i` acts only at a shift-strobe transition. Changing it while `shift_clk_i` is steady leaves the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_i | input | W | Parallel data into the latch; bit i feeds stage i |
| latch_clk_i | input | 1 | Latch strobe, acts on its rising transition |
| shift_clk_i | input | 1 | Shift strobe, acts on its rising transition |
| shift_mode_i | input | 1 | 0 = copy latch into shift register, 1 = shift serially |
| ser_i | input | 1 | Serial data into stage 0 |
| oe_ni | input | 1 | Output enable, active low |
| sdo_o | output | 1 | Serial output from stage W-1, high impedance when disabled |
| sdo_oe_o | output | 1 | 1 while `sdo_o` is driven |

## Verification
The byte 0xA5 is copied from the latch and shifted out in full. This checks the order in which stages leave. At the same time an asymmetric serial pattern is fed in and read back, which separates the serial path from the parallel path and catches a reversed shift direction. Patterns 0x0F/0xF0 are chosen so that the top bit differs between them. This shows whether a same-cycle capture-and-copy takes the old or the new latch image. Patterns 0xC0 and 0xE0 change value after a known number of shifts, so they reveal whether a strobe held high shifted more than once, and whether shifts were lost while the output was disabled.

// File: rtl/lso_pkg.sv
package lso_pkg;
  localparam int unsigned LSO_W = 8;

  typedef enum logic {
    MODE_XFER  = 1'b0,
    MODE_SHIFT = 1'b1
  } lso_mode_e;
endpackage

// File: rtl/lso_edge.sv
module lso_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/lso_latch.sv
module lso_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/lso_shreg.sv
module lso_shreg
  import lso_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  lso_mode_e    mode_i,
  input  logic         ser_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic from_prev;
    if (i == 0) begin : g_head
      assign from_prev = ser_i;
    end else begin : g_body
      assign from_prev = q_o[i-1];
    end
    assign nxt[i] = (mode_i == MODE_SHIFT) ? from_prev : par_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (step_i) q_o <= nxt;
  end
endmodule

// File: rtl/latched_shift_out.sv
module latched_shift_out
  import lso_pkg::*;
#(
  parameter int unsigned W = LSO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] par_i,
  input  logic         latch_clk_i,
  input  logic         shift_clk_i,
  input  logic         shift_mode_i,
  input  logic         ser_i,
  input  logic         oe_ni,
  output logic         sdo_o,
  output logic         sdo_oe_o
);
  localparam int unsigned TOP = W - 1;

  logic         cap_pulse, step_pulse;
  logic [W-1:0] latch_q, sr_q;
  lso_mode_e    mode;

  assign mode = lso_mode_e'(shift_mode_i);

  lso_edge u_latch_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (latch_clk_i),
    .rise_o (cap_pulse)
  );

  lso_edge u_shift_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (shift_clk_i),
    .rise_o (step_pulse)
  );

  lso_latch #(.W(W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_pulse),
    .d_i    (par_i),
    .q_o    (latch_q)
  );

  // same-edge capture: shifter sees latch_q before update
  lso_shreg #(.W(W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_pulse),
    .mode_i (mode),
    .ser_i  (ser_i),
    .par_i  (latch_q),
    .q_o    (sr_q)
  );

  assign sdo_oe_o = ~oe_ni;
  assign sdo_o    = sdo_oe_o ? sr_q[TOP] : 1'bz;
endmodule

// File: rtl/lso_chk.sv
module lso_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         latch_clk_i,
  input logic         shift_clk_i,
  input logic         shift_mode_i,
  input logic         ser_i,
  input logic [W-1:0] par_i,
  input logic         oe_ni,
  input logic         sdo_oe_o,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] sr_q
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R2
  latch_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $rose(latch_clk_i) |=> latch_q == $past(par_i));

  // R8
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$rose(latch_clk_i) |=> $stable(latch_q));

  // R3
  xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($rose(shift_clk_i) && !shift_mode_i) |=> sr_q == $past(latch_q));

  // R4
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($rose(shift_clk_i) && shift_mode_i) |=> sr_q == {$past(sr_q[W-2:0]), $past(ser_i)});

  // R9
  sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$rose(shift_clk_i) |=> $stable(sr_q));

  // R6
  oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o != oe_ni);
endmodule

bind latched_shift_out lso_chk #(.W(W)) u_lso_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .latch_clk_i  (latch_clk_i),
  .shift_clk_i  (shift_clk_i),
  .shift_mode_i (shift_mode_i),
  .ser_i        (ser_i),
  .par_i        (par_i),
  .oe_ni        (oe_ni),
  .sdo_oe_o     (sdo_oe_o),
  .latch_q      (latch_q),
  .sr_q         (sr_q)
);

// File: tb/latched_shift_out_bench.sv
module latched_shift_out_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] par = '0;
  logic         lclk = 1'b0, sclk = 1'b0, mode = 1'b0, ser = 1'b0, oen = 1'b0;
  logic         sdo, sdo_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic  oe;
    logic  d;
    bit    chk_d;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_shift_out #(.W(W)) u_latched_shift_out (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .par_i        (par),
    .latch_clk_i  (lclk),
    .shift_clk_i  (sclk),
    .shift_mode_i (mode),
    .ser_i        (ser),
    .oe_ni        (oen),
    .sdo_o        (sdo),
    .sdo_oe_o     (sdo_oe)
  );

  // monitor: pops expectations as the driver publishes them
  initial begin
    forever begin
      exp_t it;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      n_chk++;
      if (sdo_oe !== it.oe) begin
        n_fail++;
        $display("FAIL %s: sdo_oe_o=%b expected %b", it.req, sdo_oe, it.oe);
      end else if (it.chk_d && sdo !== it.d) begin
        n_fail++;
        $display("FAIL %s: sdo_o=%b expected %b", it.req, sdo, it.d);
      end
    end
  end

  task automatic cyc(input logic lc, input logic sc, input logic md, input logic si);
    @(negedge clk);
    lclk = lc; sclk = sc; mode = md; ser = si;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic oe, input logic d, input bit chk_d, input string req);
    exp_t it;
    it.oe = oe; it.d = d; it.chk_d = chk_d; it.req = req;
    exp_q.push_back(it);
    #1;
  endtask

  task automatic latch_load(input logic [W-1:0] v);
    par = v;
    cyc(1'b1, 1'b0, mode, 1'b0);
    cyc(1'b0, 1'b0, mode, 1'b0);
  endtask

  task automatic xfer(input logic exp_d, input string req);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    expect_out(1'b1, exp_d, 1'b1, req);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic shift(input logic si, input logic exp_d, input bit en, input string req);
    cyc(1'b0, 1'b1, 1'b1, si);
    expect_out(en, exp_d, en, req);
    cyc(1'b0, 1'b0, 1'b1, si);
  endtask

  initial begin
    automatic logic [W-1:0] a = 8'hA5;
    automatic logic [W-1:0] s = 8'hC9;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(1'b1, 1'b0, 1'b1, "R1");

    latch_load(a);
    expect_out(1'b1, 1'b0, 1'b1, "R2");
    xfer(a[7], "R3");

    // R4: A5 leaves top-down, then serial bits C9 in entry order
    for (int k = 0; k < 8; k++)
      shift(s[7-k], (k < 7) ? a[6-k] : s[7], 1'b1, "R4");
    for (int k = 0; k < 7; k++)
      shift(1'b0, s[6-k], 1'b1, "R4");
    shift(1'b0, 1'b0, 1'b1, "R4");

    // R9: toggle mode without shift strobe
    latch_load(8'hFF);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(1'b1, 1'b0, 1'b1, "R9");
    xfer(1'b1, "R9");

    // R5: simultaneous capture and copy
    latch_load(8'h0F);
    par = 8'hF0;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    expect_out(1'b1, 1'b0, 1'b1, "R5");
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    xfer(1'b1, "R5");

    // R6/R7: disable, shift once while disabled, re-enable
    oen = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    expect_out(1'b0, 1'b0, 1'b0, "R6");
    shift(1'b0, 1'b0, 1'b0, "R7");
    oen = 1'b0; cyc(1'b0, 1'b0, 1'b1, 1'b0);
    oen = 1'b1; cyc(1'b0, 1'b0, 1'b1, 1'b0);
    oen = 1'b0; cyc(1'b0, 1'b0, 1'b1, 1'b0);
    expect_out(1'b1, 1'b1, 1'b1, "R6");
    shift(1'b0, 1'b1, 1'b1, "R7");
    shift(1'b0, 1'b1, 1'b1, "R7");
    shift(1'b0, 1'b0, 1'b1, "R7");

    // R8: shift strobe held high shifts once (C0 -> 80)
    latch_load(8'hC0);
    xfer(1'b1, "R8");
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    expect_out(1'b1, 1'b1, 1'b1, "R8");
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    shift(1'b0, 1'b0, 1'b1, "R8");

    // R8: latch strobe held high ignores later bus change
    par = 8'h00;
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    par = 8'hFF;
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    xfer(1'b0, "R8");

    // R1: reset mid-run clears latch
    latch_load(8'hFF);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    expect_out(1'b1, 1'b0, 1'b1, "R1");
    xfer(1'b0, "R1");

    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule